// File: doc/BRIEF.md
# Flash Sector Address Generator

This block turns the host-side addressing registers of a page-organised NAND flash controller into the numbers the datapath needs. The host writes a set of eight 16-bit start-address registers and one start-buffer register. The block keeps them and, from the block and page registers, forms a linear sector index for the source of a load or program. It forms a second sector index for the destination of a copy-back. It also reports the first and last sector of a block erase. A page holds four 512-byte sectors and a block holds 64 pages, so a block spans 256 sectors.

The start-buffer register chooses which buffer RAM region the transfer uses (the boot buffer or one of two data buffers), the byte offset inside it, and how many sectors move. The block also runs the two-write boot-area load sequence. An arming value followed by a zero value requests a one-page load at the current source sector, and the page register then moves on by one page. Every output is combinational from the stored registers, except the boot-load request, which is registered.

Top module: `flash_sector_addr`

## Requirements
- R1: After reset every start-address register and the buffer address read as zero and the sector count is 1, so src_sector = 0, sec_count = 1, buf_sel = 0 and sbuf_rdata = 0.
- R2: A register write with reg_sel 0..7 stores reg_wdata into start-address register reg_sel, and reg_sel 8 writes the start-buffer register. Other select values change nothing. src_sector = page[1:0] + 4·page[7:2] + 256·block_field, where page is register 7 and block_field comes from register 0.
- R3: block_field is block register bits [11:0]. When block register bit 15 is set, it is ORed with a density mask. The mask is 1 << (6 + dev_code[6:4]) if dev_code[3] is 1, and 0 otherwise.
- R4: dst_sector uses the same formula with register 2 as the block and register 3 as the page.
- R5: A start-buffer write stores reg_wdata[11:8] as the 4-bit buffer address. It sets the sector count to reg_wdata[1:0], and a value of 0 gives a count of 4.
- R6: buf_sel is 0 (boot buffer) when buffer address bit 3 is 0. Otherwise it is 1 (data buffer 0) when bit 2 is 0 and 2 (data buffer 1) when bit 2 is 1. buf_main_off = 512·bufaddr[1:0] and buf_spare_off = 16·bufaddr[1:0].
- R7: sbuf_rdata = (bufaddr << 8) | ((count − 1) & 2).
- R8: erase_first = 256·block_field of the source block, and erase_last = erase_first + 255.
- R9: src_range_err (and dst_range_err) is 1 exactly when the corresponding block_field is at or above NUM_BLOCKS.
- R10: A boot write of 0x00E0 arms a load. If the next boot write is 0x0000, boot_load is 1 for exactly one cycle after that write, with boot_sector holding the source sector from before the write. The page register becomes (page + 4) mod 256, with no carry into the block.
- R11: While armed, a boot write of any value other than 0x0000 disarms without a load and leaves the page unchanged. A later 0x0000 without re-arming does nothing.
- R12: Boot writes other than 0x00E0 while unarmed are ignored. A boot write in the same cycle as a register write is ignored entirely, and the armed state is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_code | input | 8 | Device code giving the density mask |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select (0..7 address, 8 start buffer) |
| reg_wdata | input | 16 | Register write data |
| boot_we | input | 1 | Boot-area write strobe |
| boot_wdata | input | 16 | Boot-area write data |
| src_sector | output | SEC_W | Source sector index |
| src_range_err | output | 1 | Source block out of range |
| dst_sector | output | SEC_W | Copy-back destination sector index |
| dst_range_err | output | 1 | Destination block out of range |
| sec_count | output | 3 | Sectors to transfer (1..4) |
| buf_sel | output | 2 | Buffer region selector |
| buf_main_off | output | 11 | Byte offset in main buffer area |
| buf_spare_off | output | 6 | Byte offset in spare buffer area |
| erase_first | output | SEC_W | First sector of block erase |
| erase_last | output | SEC_W | Last sector of block erase |
| sbuf_rdata | output | 16 | Start-buffer register readback |
| boot_load | output | 1 | One-cycle boot page-load request |
| boot_sector | output | SEC_W | Sector of the boot page load |

## Verification
The bench targets the density bit. A design that ignored bit 15, or applied the mask while dev_code[3] is clear, would put the sector in the wrong block. It checks that a count field of 0 becomes 4 and that readback keeps only bit 1 of count minus one. An off-by-one here shows up as a wrong readback. It drives block numbers just below and just at the limit, which catch a comparison that is off by one or that wraps. The boot tests cover a page that wraps from 0xFE to 0x02 without touching the block, a disarm by a foreign value, and a boot write that collides with a register write. A design that carried into the block, kept the arm after a foreign value, or acted on the colliding write would load the wrong page or load when it should not.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

    localparam int ADDR_REG_N   = 8;
    localparam int BLK_REG_IDX  = 0;
    localparam int DBLK_REG_IDX = 2;
    localparam int DPG_REG_IDX  = 3;
    localparam int PAGE_REG_IDX = 7;
    localparam int SBUF_SEL     = 8;
    localparam int PAGE_F_W     = 8;
    localparam int SECT_BYTES_LG  = 9;
    localparam int SPARE_BYTES_LG = 4;

    localparam logic [15:0] BOOT_ARM_CODE  = 16'h00E0;
    localparam logic [15:0] BOOT_LOAD_CODE = 16'h0000;

    typedef enum logic [1:0] {
        BUF_BOOT  = 2'd0,
        BUF_DATA0 = 2'd1,
        BUF_DATA1 = 2'd2
    } buf_sel_e;

    typedef struct packed {
        logic [3:0] bufaddr;
        logic [2:0] count;
    } sbuf_t;

    function automatic logic [15:0] density_mask(input logic [7:0] dev);
        logic [15:0] m;
        m = 16'd1 << (6 + int'(dev[6:4]));
        return dev[3] ? m : 16'd0;
    endfunction

    function automatic logic [15:0] block_field(input logic [15:0] blk,
                                                input logic [7:0]  dev);
        return {4'd0, blk[11:0]} | (blk[15] ? density_mask(dev) : 16'd0);
    endfunction

    function automatic logic [2:0] decode_count(input logic [1:0] f);
        return (f == 2'd0) ? 3'd4 : {1'b0, f};
    endfunction

endpackage

// File: rtl/fsa_regs.sv
module fsa_regs
    import fsa_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [3:0]  reg_sel,
    input  logic [15:0] reg_wdata,
    input  logic        page_adv,
    output logic [15:0] addr_q [ADDR_REG_N],
    output sbuf_t       sbuf_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ADDR_REG_N; i++) addr_q[i] <= '0;
            sbuf_q.bufaddr <= '0;
            sbuf_q.count   <= 3'd1;
        end else begin
            for (int i = 0; i < ADDR_REG_N; i++) begin
                if (reg_we && reg_sel == 4'(i))
                    addr_q[i] <= reg_wdata;
                else if (i == PAGE_REG_IDX && page_adv)
                    addr_q[i] <= {8'd0, addr_q[i][PAGE_F_W-1:0] + 8'd4};
            end
            if (reg_we && reg_sel == 4'(SBUF_SEL)) begin
                sbuf_q.bufaddr <= reg_wdata[11:8];
                sbuf_q.count   <= decode_count(reg_wdata[1:0]);
            end
        end
    end

    // R5
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        sbuf_q.count >= 3'd1 && sbuf_q.count <= 3'd4);

endmodule

// File: rtl/fsa_sector_calc.sv
module fsa_sector_calc
    import fsa_pkg::*;
#(
    parameter int BF_W       = 14,
    parameter int NUM_BLOCKS = 2048,
    localparam int SEC_W     = BF_W + PAGE_F_W
) (
    input  logic [15:0]      blk_reg,
    input  logic [15:0]      page_reg,
    input  logic [7:0]       dev_code,
    output logic [SEC_W-1:0] sector,
    output logic [BF_W-1:0]  bfield,
    output logic             range_err
);

    logic [15:0] bf_full;

    always_comb begin
        bf_full   = block_field(blk_reg, dev_code);
        bfield    = bf_full[BF_W-1:0];
        range_err = 32'(bf_full) >= NUM_BLOCKS;
        // four sectors per page, 64 pages per block: page bits sit below the block
        sector    = {bfield, page_reg[PAGE_F_W-1:2], page_reg[1:0]};
    end

endmodule

// File: rtl/fsa_boot_seq.sv
module fsa_boot_seq
    import fsa_pkg::*;
#(
    parameter int SEC_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             boot_we,
    input  logic [15:0]      boot_wdata,
    input  logic             reg_we,
    input  logic [SEC_W-1:0] cur_sector,
    output logic             page_adv,
    output logic             boot_load,
    output logic [SEC_W-1:0] boot_sector
);

    logic armed;
    logic accept;

    always_comb begin
        accept   = boot_we && !reg_we;
        page_adv = accept && armed && boot_wdata == BOOT_LOAD_CODE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed       <= 1'b0;
            boot_load   <= 1'b0;
            boot_sector <= '0;
        end else begin
            boot_load <= page_adv;
            if (page_adv) boot_sector <= cur_sector;
            if (accept) armed <= !armed && boot_wdata == BOOT_ARM_CODE;
        end
    end

    // R10
    boot_pulse_armed_chk: assert property (@(posedge clk) disable iff (rst)
        boot_load |-> $past(armed) && !armed);

    // R10
    boot_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        boot_load |=> !boot_load);

endmodule

// File: rtl/flash_sector_addr.sv
module flash_sector_addr
    import fsa_pkg::*;
#(
    parameter int BF_W       = 14,
    parameter int NUM_BLOCKS = 2048,
    localparam int SEC_W     = BF_W + PAGE_F_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       dev_code,
    input  logic             reg_we,
    input  logic [3:0]       reg_sel,
    input  logic [15:0]      reg_wdata,
    input  logic             boot_we,
    input  logic [15:0]      boot_wdata,
    output logic [SEC_W-1:0] src_sector,
    output logic             src_range_err,
    output logic [SEC_W-1:0] dst_sector,
    output logic             dst_range_err,
    output logic [2:0]       sec_count,
    output logic [1:0]       buf_sel,
    output logic [10:0]      buf_main_off,
    output logic [5:0]       buf_spare_off,
    output logic [SEC_W-1:0] erase_first,
    output logic [SEC_W-1:0] erase_last,
    output logic [15:0]      sbuf_rdata,
    output logic             boot_load,
    output logic [SEC_W-1:0] boot_sector
);

    logic [15:0]      addr_q [ADDR_REG_N];
    sbuf_t            sbuf_q;
    logic             page_adv;
    logic [SEC_W-1:0] sec_v [2];
    logic [BF_W-1:0]  bf_v  [2];
    logic             err_v [2];
    logic [2:0]       cnt_m1;
    buf_sel_e         bsel;

    fsa_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .page_adv  (page_adv),
        .addr_q    (addr_q),
        .sbuf_q    (sbuf_q)
    );

    // port 0: source (block reg 0, page reg 7); port 1: copy-back destination
    for (genvar g = 0; g < 2; g++) begin : g_calc
        localparam int BI = (g == 0) ? BLK_REG_IDX  : DBLK_REG_IDX;
        localparam int PI = (g == 0) ? PAGE_REG_IDX : DPG_REG_IDX;
        fsa_sector_calc #(.BF_W(BF_W), .NUM_BLOCKS(NUM_BLOCKS)) u_calc (
            .blk_reg   (addr_q[BI]),
            .page_reg  (addr_q[PI]),
            .dev_code  (dev_code),
            .sector    (sec_v[g]),
            .bfield    (bf_v[g]),
            .range_err (err_v[g])
        );
    end

    fsa_boot_seq #(.SEC_W(SEC_W)) u_boot (
        .clk         (clk),
        .rst         (rst),
        .boot_we     (boot_we),
        .boot_wdata  (boot_wdata),
        .reg_we      (reg_we),
        .cur_sector  (sec_v[0]),
        .page_adv    (page_adv),
        .boot_load   (boot_load),
        .boot_sector (boot_sector)
    );

    always_comb begin
        src_sector    = sec_v[0];
        src_range_err = err_v[0];
        dst_sector    = sec_v[1];
        dst_range_err = err_v[1];
        erase_first   = {bf_v[0], 8'h00};
        erase_last    = {bf_v[0], 8'hFF};
        sec_count     = sbuf_q.count;
        cnt_m1        = sbuf_q.count - 3'd1;
        sbuf_rdata    = {4'd0, sbuf_q.bufaddr, 6'd0, cnt_m1[1], 1'b0};
        if (!sbuf_q.bufaddr[3])     bsel = BUF_BOOT;
        else if (sbuf_q.bufaddr[2]) bsel = BUF_DATA1;
        else                        bsel = BUF_DATA0;
        buf_sel       = bsel;
        buf_main_off  = 11'(sbuf_q.bufaddr[1:0]) << SECT_BYTES_LG;
        buf_spare_off = 6'(sbuf_q.bufaddr[1:0]) << SPARE_BYTES_LG;
    end

    // R10
    page_advance_chk: assert property (@(posedge clk) disable iff (rst)
        boot_load |-> addr_q[PAGE_REG_IDX][7:0] == $past(addr_q[PAGE_REG_IDX][7:0]) + 8'd4);

    // R9
    range_err_chk: assert property (@(posedge clk) disable iff (rst)
        src_range_err |-> 32'(erase_first[SEC_W-1:8]) >= NUM_BLOCKS);

    // R6
    buf_sel_legal_chk: assert property (@(posedge clk) disable iff (rst)
        buf_sel != 2'd3);

endmodule

// File: tb/flash_sector_addr_test.sv
module flash_sector_addr_test;

    localparam int SW = 22;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    dev_code = '0;
    logic          reg_we = 1'b0;
    logic [3:0]    reg_sel = '0;
    logic [15:0]   reg_wdata = '0;
    logic          boot_we = 1'b0;
    logic [15:0]   boot_wdata = '0;
    logic [SW-1:0] src_sector, dst_sector, erase_first, erase_last, boot_sector;
    logic          src_range_err, dst_range_err, boot_load;
    logic [2:0]    sec_count;
    logic [1:0]    buf_sel;
    logic [10:0]   buf_main_off;
    logic [5:0]    buf_spare_off;
    logic [15:0]   sbuf_rdata;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    flash_sector_addr uut (
        .clk(clk), .rst(rst), .dev_code(dev_code),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .boot_we(boot_we), .boot_wdata(boot_wdata),
        .src_sector(src_sector), .src_range_err(src_range_err),
        .dst_sector(dst_sector), .dst_range_err(dst_range_err),
        .sec_count(sec_count), .buf_sel(buf_sel),
        .buf_main_off(buf_main_off), .buf_spare_off(buf_spare_off),
        .erase_first(erase_first), .erase_last(erase_last),
        .sbuf_rdata(sbuf_rdata), .boot_load(boot_load), .boot_sector(boot_sector)
    );

    // {block reg, page reg, dev_code, expected sector, expected range error}
    localparam logic [62:0] VEC [0:7] = '{
        {16'h0000, 16'h0000, 8'h00, 22'h000000, 1'b0},
        {16'h0001, 16'h0005, 8'h00, 22'h000105, 1'b0},
        {16'h0123, 16'h00FF, 8'h00, 22'h0123FF, 1'b0},
        {16'h8005, 16'h0002, 8'h28, 22'h010502, 1'b0},
        {16'h8005, 16'h0002, 8'h20, 22'h000502, 1'b0},
        {16'h0800, 16'h0000, 8'h00, 22'h080000, 1'b1},
        {16'h87FF, 16'h0010, 8'h58, 22'h0FFF10, 1'b1},
        {16'h07FF, 16'h0081, 8'h08, 22'h07FF81, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] sel, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wr_boot(input logic [15:0] d);
        @(negedge clk);
        boot_we = 1'b1; boot_wdata = d;
        @(negedge clk);
        boot_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 src_sector", 32'(src_sector), 0);
        chk("R1 sec_count", 32'(sec_count), 1);
        chk("R1 sbuf_rdata", 32'(sbuf_rdata), 0);
        chk("R1 buf_sel", 32'(buf_sel), 0);
        chk("R1 boot_load", 32'(boot_load), 0);

        // table of source-address vectors (R2, R3, R8, R9)
        for (int i = 0; i < 8; i++) begin
            dev_code = VEC[i][30:23];
            wr_reg(4'd0, VEC[i][62:47]);
            wr_reg(4'd7, VEC[i][46:31]);
            chk("R2/R3 src_sector", 32'(src_sector), 32'(VEC[i][22:1]));
            chk("R9 src_range_err", 32'(src_range_err), 32'(VEC[i][0]));
            chk("R8 erase_first", 32'(erase_first), 32'(VEC[i][22:1]) & 32'hFFFFFF00);
            chk("R8 erase_last", 32'(erase_last), 32'(VEC[i][22:1]) | 32'hFF);
        end

        // R4 destination, with density mask 0x40
        dev_code = 8'h08;
        wr_reg(4'd2, 16'h8001);
        wr_reg(4'd3, 16'h0041);
        chk("R4 dst_sector", 32'(dst_sector), 32'h4141);
        chk("R9 dst_range_err low", 32'(dst_range_err), 0);
        wr_reg(4'd2, 16'h0900);
        chk("R9 dst_range_err high", 32'(dst_range_err), 1);
        chk("R4 dst_sector high", 32'(dst_sector), 32'h90041);

        // R5 R6 R7 start buffer
        wr_reg(4'd8, 16'h0000);
        chk("R5 count zero->4", 32'(sec_count), 4);
        chk("R7 readback count4", 32'(sbuf_rdata), 32'h0002);
        chk("R6 boot sel", 32'(buf_sel), 0);
        wr_reg(4'd8, 16'h0A01);
        chk("R5 count1", 32'(sec_count), 1);
        chk("R6 data0 sel", 32'(buf_sel), 1);
        chk("R6 main off", 32'(buf_main_off), 1024);
        chk("R6 spare off", 32'(buf_spare_off), 32);
        chk("R7 readback A01", 32'(sbuf_rdata), 32'h0A00);
        wr_reg(4'd8, 16'h0F03);
        chk("R6 data1 sel", 32'(buf_sel), 2);
        chk("R6 main off 3", 32'(buf_main_off), 1536);
        chk("R6 spare off 3", 32'(buf_spare_off), 48);
        chk("R7 readback F03", 32'(sbuf_rdata), 32'h0F02);
        wr_reg(4'd8, 16'h0402);
        chk("R6 boot with bit2", 32'(buf_sel), 0);
        chk("R7 readback 402", 32'(sbuf_rdata), 32'h0400);

        // R2 unused select and untouched register
        dev_code = 8'h00;
        wr_reg(4'd0, 16'h0003);
        wr_reg(4'd7, 16'h0008);
        wr_reg(4'd9, 16'h0F03);
        chk("R2 unused sel buffer", 32'(sbuf_rdata), 32'h0400);
        chk("R2 unused sel sector", 32'(src_sector), 32'h308);
        wr_reg(4'd1, 16'hFFFF);
        chk("R2 reg1 no effect", 32'(src_sector), 32'h308);

        // R10 boot load
        wr_boot(16'h00E0);
        chk("R10 no load on arm", 32'(boot_load), 0);
        wr_boot(16'h0000);
        chk("R10 boot_load", 32'(boot_load), 1);
        chk("R10 boot_sector", 32'(boot_sector), 32'h308);
        chk("R10 page advanced", 32'(src_sector), 32'h30C);
        @(negedge clk);
        chk("R10 single pulse", 32'(boot_load), 0);
        wr_reg(4'd7, 16'h00FE);
        wr_boot(16'h00E0);
        wr_boot(16'h0000);
        chk("R10 wrap boot_sector", 32'(boot_sector), 32'h3FE);
        chk("R10 wrap no carry", 32'(src_sector), 32'h302);

        // R11 disarm
        wr_boot(16'h00E0);
        wr_boot(16'h1234);
        chk("R11 no load", 32'(boot_load), 0);
        wr_boot(16'h0000);
        chk("R11 not rearmed", 32'(boot_load), 0);
        chk("R11 page kept", 32'(src_sector), 32'h302);

        // R12 unarmed foreign value, collision with register write
        wr_boot(16'h0090);
        wr_boot(16'h0000);
        chk("R12 unarmed ignored", 32'(boot_load), 0);
        wr_boot(16'h00E0);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 4'd0; reg_wdata = 16'h0005;
        boot_we = 1'b1; boot_wdata = 16'h0000;
        @(negedge clk);
        reg_we = 1'b0; boot_we = 1'b0;
        chk("R12 collision no load", 32'(boot_load), 0);
        chk("R12 collision page kept", 32'(src_sector), 32'h502);
        wr_boot(16'h0000);
        chk("R12 arm kept", 32'(boot_load), 1);
        chk("R12 arm kept sector", 32'(boot_sector), 32'h502);
        chk("R12 arm kept advance", 32'(src_sector), 32'h506);

        // R1 reset after activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset sector", 32'(src_sector), 0);
        chk("R1 reset count", 32'(sec_count), 1);
        chk("R1 reset readback", 32'(sbuf_rdata), 0);
        chk("R1 reset dst", 32'(dst_sector), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule